// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block manages eight interrupt request lines on behalf of a processor. Each line is captured into a pending set, and a per-line enable mask screens it. The block then picks the most urgent unmasked request under a fixed order in which line 0 is the most urgent and line 7 the least. It raises a single interrupt output only when that request is more urgent than every level the processor is already servicing.

When the processor acknowledges, the block drops the interrupt output. It presents a vector byte for one cycle, built from a software-set base in the upper bits and the granted line number in the lower bits. It also records that line as in service. Software uses a small write port to load the mask, the vector base and the capture mode, and to issue a non-specific end-of-service command. That command retires the most urgent in-service level, so less urgent requests can interrupt again.

Lines are captured either on a rising transition (the default) or by level. In level mode a request that goes away before acknowledge is not granted.

Top module: `vpic_top`

## Requirements
- R1: After reset `int_out`, `vec_valid` and `vec_out` are 0, every line is masked (mask register all ones), the capture mode is edge, the vector base is 0 and no level is in service.
- R2: In edge mode a 0-to-1 transition on `irq_in[i]` latches a request. If that request is unmasked and outranks everything in service, `int_out` rises on the second rising clock edge after the input changes. An input that stays high does not request again once its request has been granted.
- R3: A write with `reg_sel`=0 loads the mask, where `reg_wdata[i]`=1 masks line i. A masked request never raises `int_out` and does not affect other lines. A transition latched while the line was masked stays pending and raises `int_out` one edge after the line is unmasked.
- R4: Among pending unmasked requests, the lowest line index wins; line 0 is the most urgent.
- R5: When `inta` is high at a clock edge, `int_out` is 0 after that edge. `vec_valid` is 1 for exactly that one cycle, with `vec_out` = {base, line[2:0]} of the granted line. The granted line is then in service.
- R6: A write with `reg_sel`=1 loads the 5-bit vector base from `reg_wdata[4:0]`, which forms `vec_out[7:3]`.
- R7: While line L is in service, requests on lines L..7 do not raise `int_out`, and a request on a line below L does.
- R8: A write with `reg_sel`=3 (end of service) clears only the most urgent in-service level. `int_out` re-evaluates on the next edge after the write.
- R9: A write with `reg_sel`=2 sets the capture mode from `reg_wdata[0]` (1 = level). In level mode the pending state follows the input. A request removed before acknowledge is not granted, and a request still held after end of service interrupts again.
- R10: An acknowledge with no eligible request gives `vec_out` = {base, 3'd7} and marks nothing in service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 8 | Interrupt request lines, line 0 most urgent |
| inta | input | 1 | Acknowledge, one-cycle pulse |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 mask, 1 base, 2 mode, 3 end of service |
| reg_wdata | input | 8 | Register write data |
| int_out | output | 1 | Interrupt request to the processor |
| vec_valid | output | 1 | Vector byte valid, one cycle after acknowledge |
| vec_out | output | 8 | Vector byte |

## Verification
A change on a request line passes through the pending register and then the interrupt register. The bench therefore checks `int_out` low after one edge and high after the second. A mask, mode or end-of-service write takes effect at its own edge, so its effect on `int_out` is sampled one edge later. An acknowledge updates `vec_out`, `vec_valid` and `int_out` at the same edge it is sampled, so these are read at the falling edge that follows it. `vec_valid` is read low again one edge after that. All inputs change and all outputs are read on falling edges, well away from the capturing edge.

// File: rtl/vpic_pkg.sv
package vpic_pkg;
   typedef enum logic [1:0] {
      SEL_MASK = 2'd0,
      SEL_BASE = 2'd1,
      SEL_MODE = 2'd2,
      SEL_EOS  = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/vpic_prio_pick.sv
module vpic_prio_pick #(
   parameter int NUM_LINES = 8,
   parameter int LVL_W     = $clog2(NUM_LINES)
) (
   input  logic [NUM_LINES-1:0] req_vec,
   output logic                 any_set,
   output logic [LVL_W-1:0]     top_idx
);
   // lowest index wins: scan from the top so the last hit is the lowest
   always_comb begin
      any_set = 1'b0;
      top_idx = '0;
      for (int i = NUM_LINES - 1; i >= 0; i--) begin
         if (req_vec[i]) begin
            any_set = 1'b1;
            top_idx = LVL_W'(i);
         end
      end
   end
endmodule

// File: rtl/vpic_req_capture.sv
module vpic_req_capture #(
   parameter int NUM_LINES = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] irq_in,
   input  logic                 level_mode,
   input  logic [NUM_LINES-1:0] clr_vec,
   output logic [NUM_LINES-1:0] irr_q
);
   genvar g;
   generate
      for (g = 0; g < NUM_LINES; g++) begin : g_line
         logic prev_q;
         logic pend_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               prev_q <= 1'b0;
               pend_q <= 1'b0;
            end else begin
               prev_q <= irq_in[g];
               if (level_mode)
                  pend_q <= irq_in[g];
               else
                  pend_q <= (pend_q | (irq_in[g] & ~prev_q)) & ~clr_vec[g];
            end
         end
         assign irr_q[g] = pend_q;
      end
   endgenerate
endmodule

// File: rtl/vpic_isr_track.sv
module vpic_isr_track #(
   parameter int NUM_LINES = 8,
   parameter int LVL_W     = $clog2(NUM_LINES)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 set_en,
   input  logic [LVL_W-1:0]     set_idx,
   input  logic                 eos,
   output logic [NUM_LINES-1:0] isr_q,
   output logic                 isr_any,
   output logic [LVL_W-1:0]     isr_idx
);
   logic [NUM_LINES-1:0] set_vec;
   logic [NUM_LINES-1:0] clr_vec;

   vpic_prio_pick #(.NUM_LINES(NUM_LINES), .LVL_W(LVL_W)) u_isr_pick (
      .req_vec (isr_q),
      .any_set (isr_any),
      .top_idx (isr_idx)
   );

   always_comb begin
      set_vec = '0;
      clr_vec = '0;
      if (set_en) set_vec = NUM_LINES'(1) << set_idx;
      if (eos && isr_any) clr_vec = NUM_LINES'(1) << isr_idx;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) isr_q <= '0;
      else        isr_q <= (isr_q & ~clr_vec) | set_vec;
   end
endmodule

// File: rtl/vpic_top.sv
module vpic_top #(
   parameter int NUM_LINES = 8,
   parameter int VEC_W     = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] irq_in,
   input  logic                 inta,
   input  logic                 reg_we,
   input  logic [1:0]           reg_sel,
   input  logic [VEC_W-1:0]     reg_wdata,
   output logic                 int_out,
   output logic                 vec_valid,
   output logic [VEC_W-1:0]     vec_out
);
   import vpic_pkg::*;

   localparam int LVL_W  = $clog2(NUM_LINES);
   localparam int BASE_W = VEC_W - LVL_W;
   localparam logic [LVL_W-1:0] SPUR_LVL = LVL_W'(NUM_LINES - 1);

   generate
      if (NUM_LINES < 2 || NUM_LINES != (1 << LVL_W))
         $error("vpic_top: NUM_LINES must be a power of two of at least 2");
      if (VEC_W <= LVL_W || VEC_W < NUM_LINES)
         $error("vpic_top: VEC_W too narrow for level field or mask");
   endgenerate

   logic [NUM_LINES-1:0] imr_q;
   logic [BASE_W-1:0]    base_q;
   logic                 level_q;
   logic                 int_q;
   logic                 vvalid_q;
   logic [VEC_W-1:0]     vec_q;

   logic [NUM_LINES-1:0] irr_q;
   logic [NUM_LINES-1:0] isr_q;
   logic [NUM_LINES-1:0] pend_vec;
   logic [NUM_LINES-1:0] irr_clr;
   logic                 pend_any, isr_any;
   logic [LVL_W-1:0]     pend_idx, isr_idx;
   logic                 want, grant, eos_wr;
   reg_sel_e             sel;

   assign sel      = reg_sel_e'(reg_sel);
   assign eos_wr   = reg_we && (sel == SEL_EOS);
   assign pend_vec = irr_q & ~imr_q;

   vpic_req_capture #(.NUM_LINES(NUM_LINES)) u_capture (
      .clk        (clk),
      .rst_n      (rst_n),
      .irq_in     (irq_in),
      .level_mode (level_q),
      .clr_vec    (irr_clr),
      .irr_q      (irr_q)
   );

   vpic_prio_pick #(.NUM_LINES(NUM_LINES), .LVL_W(LVL_W)) u_pend_pick (
      .req_vec (pend_vec),
      .any_set (pend_any),
      .top_idx (pend_idx)
   );

   vpic_isr_track #(.NUM_LINES(NUM_LINES), .LVL_W(LVL_W)) u_isr (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_en  (grant),
      .set_idx (pend_idx),
      .eos     (eos_wr),
      .isr_q   (isr_q),
      .isr_any (isr_any),
      .isr_idx (isr_idx)
   );

   // a request is eligible only if strictly more urgent than all in service
   assign want    = pend_any && (!isr_any || (pend_idx < isr_idx));
   assign grant   = inta && want;
   assign irr_clr = grant ? (NUM_LINES'(1) << pend_idx) : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         imr_q   <= '1;
         base_q  <= '0;
         level_q <= 1'b0;
      end else if (reg_we) begin
         case (sel)
            SEL_MASK: imr_q   <= reg_wdata[NUM_LINES-1:0];
            SEL_BASE: base_q  <= reg_wdata[BASE_W-1:0];
            SEL_MODE: level_q <= reg_wdata[0];
            default:  ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         int_q    <= 1'b0;
         vvalid_q <= 1'b0;
         vec_q    <= '0;
      end else begin
         int_q    <= inta ? 1'b0 : want;
         vvalid_q <= inta;
         if (inta) vec_q <= {base_q, (grant ? pend_idx : SPUR_LVL)};
      end
   end

   assign int_out   = int_q;
   assign vec_valid = vvalid_q;
   assign vec_out   = vec_q;
endmodule

// File: rtl/vpic_chk.sv
module vpic_chk #(
   parameter int NUM_LINES = 8,
   parameter int VEC_W     = 8,
   parameter int BASE_W    = 5
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 inta,
   input logic                 int_out,
   input logic                 vec_valid,
   input logic [VEC_W-1:0]     vec_out,
   input logic [BASE_W-1:0]    base_q,
   input logic [NUM_LINES-1:0] irr_q,
   input logic [NUM_LINES-1:0] imr_q,
   input logic [NUM_LINES-1:0] isr_q
);
   AST_ACK_DROPS_INT: assert property (@(posedge clk) disable iff (!rst_n)
      inta |=> !int_out); // R5

   AST_VEC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      !inta |=> !vec_valid); // R5

   AST_VEC_BASE_BITS: assert property (@(posedge clk) disable iff (!rst_n)
      vec_valid |-> (vec_out[VEC_W-1:VEC_W-BASE_W] == $past(base_q))); // R6

   AST_INT_NEEDS_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
      int_out |-> ($past(irr_q & ~imr_q) != '0)); // R3

   AST_LVL0_BLOCKS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      int_out |-> !$past(isr_q[0])); // R7

   AST_SERVICE_ONLY_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(inta) |-> ((isr_q & ~$past(isr_q)) == '0)); // R5

   AST_SERVICE_ONE_AT_A_TIME: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(isr_q & ~$past(isr_q)) <= 1); // R5
endmodule

bind vpic_top vpic_chk #(
   .NUM_LINES (NUM_LINES),
   .VEC_W     (VEC_W),
   .BASE_W    (BASE_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .inta      (inta),
   .int_out   (int_out),
   .vec_valid (vec_valid),
   .vec_out   (vec_out),
   .base_q    (base_q),
   .irr_q     (irr_q),
   .imr_q     (imr_q),
   .isr_q     (isr_q)
);

// File: tb/vpic_top_bench.sv
`timescale 1ns/1ps
module vpic_top_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] irq_in = '0;
   logic       inta = 1'b0;
   logic       reg_we = 1'b0;
   logic [1:0] reg_sel = '0;
   logic [7:0] reg_wdata = '0;
   logic       int_out, vec_valid;
   logic [7:0] vec_out;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   vpic_top u_vpic_top (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .inta(inta),
      .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
      .int_out(int_out), .vec_valid(vec_valid), .vec_out(vec_out)
   );

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] sel, input logic [7:0] data);
      reg_we = 1'b1; reg_sel = sel; reg_wdata = data;
      tick(1);
      reg_we = 1'b0;
   endtask

   task automatic ack_expect(input string tag, input logic [7:0] exp_vec);
      inta = 1'b1;
      tick(1);
      inta = 1'b0;
      chk({tag, " vec_valid"}, 8'(vec_valid), 8'd1);
      chk({tag, " vec_out"}, vec_out, exp_vec);
      chk({tag, " int_out low after ack"}, 8'(int_out), 8'd0);
   endtask

   task automatic t_reset_and_mask;
      chk("R1 int_out", 8'(int_out), 8'd0);
      chk("R1 vec_valid", 8'(vec_valid), 8'd0);
      chk("R1 vec_out", vec_out, 8'd0);
      irq_in[3] = 1'b1;
      tick(3);
      chk("R1 all masked at reset", 8'(int_out), 8'd0);
      wr(2'd0, 8'h00);
      tick(1);
      chk("R3 latched while masked", 8'(int_out), 8'd1);
      ack_expect("R5 base0 line3", 8'h03);
      tick(1);
      chk("R5 vec_valid one cycle", 8'(vec_valid), 8'd0);
      wr(2'd3, 8'h00);
      tick(2);
      chk("R2 held input no re-request", 8'(int_out), 8'd0);
      irq_in = '0;
      tick(2);
   endtask

   task automatic t_priority_nesting;
      wr(2'd1, 8'h15);
      irq_in[5] = 1'b1; irq_in[2] = 1'b1;
      tick(1);
      chk("R2 int_out not after one edge", 8'(int_out), 8'd0);
      tick(1);
      chk("R2 int_out after two edges", 8'(int_out), 8'd1);
      ack_expect("R4 R6 line2 wins", 8'hAA);
      tick(2);
      chk("R7 lower line blocked", 8'(int_out), 8'd0);
      irq_in[1] = 1'b1;
      tick(2);
      chk("R7 higher line nests", 8'(int_out), 8'd1);
      ack_expect("R7 nested vector", 8'hA9);
      wr(2'd3, 8'h00);
      tick(1);
      chk("R8 clears only top level", 8'(int_out), 8'd0);
      wr(2'd3, 8'h00);
      tick(1);
      chk("R8 second clear releases line5", 8'(int_out), 8'd1);
      ack_expect("R8 line5 vector", 8'hAD);
      wr(2'd3, 8'h00);
      irq_in = '0;
      tick(2);
   endtask

   task automatic t_single_mask;
      wr(2'd0, 8'h04);
      irq_in[2] = 1'b1; irq_in[6] = 1'b1;
      tick(2);
      chk("R3 unmasked line still interrupts", 8'(int_out), 8'd1);
      ack_expect("R3 masked line2 skipped", 8'hAE);
      wr(2'd3, 8'h00);
      wr(2'd0, 8'h00);
      tick(1);
      chk("R3 unmask releases latched line2", 8'(int_out), 8'd1);
      ack_expect("R3 line2 vector", 8'hAA);
      wr(2'd3, 8'h00);
      irq_in = '0;
      tick(2);
   endtask

   task automatic t_level_and_spurious;
      wr(2'd2, 8'h01);
      irq_in[4] = 1'b1;
      tick(2);
      chk("R9 level request", 8'(int_out), 8'd1);
      irq_in[4] = 1'b0;
      tick(2);
      chk("R9 removed request drops", 8'(int_out), 8'd0);
      ack_expect("R10 spurious vector", 8'hAF);
      irq_in[7] = 1'b1;
      tick(2);
      chk("R10 nothing put in service", 8'(int_out), 8'd1);
      ack_expect("R10 line7 real grant", 8'hAF);
      wr(2'd3, 8'h00);
      irq_in[7] = 1'b0;
      tick(2);
      irq_in[4] = 1'b1;
      tick(2);
      ack_expect("R9 level line4", 8'hAC);
      wr(2'd3, 8'h00);
      tick(1);
      chk("R9 held level re-requests", 8'(int_out), 8'd1);
      irq_in[4] = 1'b0;
      tick(2);
      chk("R9 released level idle", 8'(int_out), 8'd0);
   endtask

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(1);
      t_reset_and_mask();
      t_priority_nesting();
      t_single_mask();
      t_level_and_spurious();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule